// File: doc/BRIEF.md
# Prioritized pending interrupt selector

This block holds the per-line state of a fixed set of interrupt IDs: an enable bit, a pending bit, the last seen input level and an edge/level trigger flag, plus an 8-bit priority for each ID. It samples external request wires and turns their transitions into pending bits according to each line's trigger mode. Set and clear strobes for enable and pending, configuration writes and the running priority all arrive from surrounding logic. The block itself has no bus decoding and no acknowledge or completion handling.

Every cycle a balanced comparison tree searches all IDs that are enabled and pending for the most urgent one. The result is gated by two global enables, by a programmable priority mask and by the running priority. It is then registered as a single request wire to the processor and a highest-pending ID.

Top module: `irq_prio_select`

## Requirements
- R1: There are 96 interrupt IDs (0..95). External wire `ext_irq[n]` drives ID n+32. IDs 0..31 have no wire, and their stored level stays 0.
- R2: An ID competes only when it is both enabled and pending. A numerically lower 8-bit priority is more urgent. When priorities are equal, the lower ID wins.
- R3: While the distributor enable or the processor enable is 0, `irq_req` is 0 and `hp_id` is 1023.
- R4: When the winner's priority is numerically greater than the 8-bit mask, `irq_req` is 0 and `hp_id` is 1023. A priority equal to the mask passes. With no competitor the best priority is 0x100, which always fails the mask.
- R5: Otherwise `hp_id` is the winning ID. `irq_req` is 1 only when the winner's priority is strictly below the 9-bit `run_pri`, where 0x100 means nothing is running.
- R6: A rising external wire sets the line's level bit. It sets pending when the line is edge-triggered (`cfg_edge`=1) or enabled. A wire held at its stored level has no effect.
- R7: A falling external wire clears only the level bit. A pending bit already set stays set.
- R8: Setting the enable of a level-triggered line whose stored level is 1 sets its pending bit.
- R9: Reset clears all per-ID bits and priorities. It then makes IDs 0..14 enabled and edge-triggered, sets the mask to 0xF0 and both global enables to 0. The outputs reset to `irq_req`=0 and `hp_id`=1023.
- R10: When a set strobe and a clear strobe hit the same pending bit or the same enable bit in one cycle, the set wins.
- R11: Line state, priorities, mask and enables update at the clock edge that samples a write. The outputs reflect that state one edge later. A `run_pri` change reaches `irq_req` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 64 | External request wires, wire n maps to ID n+32 |
| glb_en_wr | input | 1 | Write strobe for the distributor enable |
| glb_en_val | input | 1 | Distributor enable value |
| cpu_en_wr | input | 1 | Write strobe for the processor enable |
| cpu_en_val | input | 1 | Processor enable value |
| mask_wr | input | 1 | Write strobe for the priority mask |
| mask_val | input | 8 | Priority mask value |
| en_set | input | 96 | Per-ID enable set strobes |
| en_clr | input | 96 | Per-ID enable clear strobes |
| pend_set | input | 96 | Per-ID pending set strobes |
| pend_clr | input | 96 | Per-ID pending clear strobes |
| cfg_wr | input | 1 | Trigger mode write strobe |
| cfg_id | input | 10 | ID whose trigger mode is written |
| cfg_edge | input | 1 | 1 = edge-triggered, 0 = level-triggered |
| pri_wr | input | 1 | Priority write strobe |
| pri_id | input | 10 | ID whose priority is written |
| pri_val | input | 8 | Priority value |
| run_pri | input | 9 | Priority of the interrupt being serviced, 0x100 = idle |
| irq_req | output | 1 | Registered request to the processor |
| hp_id | output | 10 | Registered highest-pending ID, 1023 = none |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Equal priorities on two IDs: a tree that prefers the right branch would report the higher ID.
- A priority exactly equal to the mask: an off-by-one compare would hide the winner or leak one priority level too many.
- A running priority equal to the winner's: a `<=` compare would raise a request that must stay low.
- A level-triggered line that is disabled while its wire rises: it must only record the level, so a design that sets pending would show a spurious `hp_id`.
- Enabling that same line afterwards must set pending at once.
- A set strobe and a clear strobe landing together on one bit: a design that lets the clear win would lose the bit.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int unsigned ID_W   = 10;
    localparam int unsigned PRI_W  = 8;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

    // one contender in the search tree; pri is one bit wider so that an
    // empty slot (0x100) loses against every real priority
    typedef struct packed {
        logic [PRI_W:0]  pri;
        logic [ID_W-1:0] id;
    } cand_t;

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_IRQ    = 96,
    parameter int unsigned EXT_BASE = 32,
    parameter int unsigned N_BOOT   = 15,
    localparam int unsigned N_EXT   = N_IRQ - EXT_BASE
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_in,
    input  logic [N_IRQ-1:0]  en_set,
    input  logic [N_IRQ-1:0]  en_clr,
    input  logic [N_IRQ-1:0]  pd_set,
    input  logic [N_IRQ-1:0]  pd_clr,
    input  logic              cfg_wr,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_edge,
    output logic [N_IRQ-1:0]  en_q,
    output logic [N_IRQ-1:0]  pd_q,
    output logic [N_IRQ-1:0]  lvl_q,
    output logic [N_IRQ-1:0]  edge_q
);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic wire_lvl;
        logic rise;
        logic set_pd;

        if (g >= EXT_BASE) begin : g_ext
            assign wire_lvl = ext_in[g-EXT_BASE];
        end else begin : g_int
            assign wire_lvl = 1'b0;
        end

        assign rise   = wire_lvl & ~lvl_q[g];
        assign set_pd = pd_set[g]
                      | (rise & (edge_q[g] | en_q[g]))
                      | (en_set[g] & lvl_q[g] & ~edge_q[g]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g]   <= (g < N_BOOT);
                edge_q[g] <= (g < N_BOOT);
                pd_q[g]   <= 1'b0;
                lvl_q[g]  <= 1'b0;
            end else begin
                lvl_q[g] <= wire_lvl;
                if (set_pd)          pd_q[g] <= 1'b1;
                else if (pd_clr[g])  pd_q[g] <= 1'b0;
                if (en_set[g])       en_q[g] <= 1'b1;
                else if (en_clr[g])  en_q[g] <= 1'b0;
                if (cfg_wr && cfg_id == ID_W'(g))
                    edge_q[g] <= cfg_edge;
            end
        end
    end

endmodule

// File: rtl/irq_pri_store.sv
module irq_pri_store
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_IRQ = 96
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pri_wr,
    input  logic [ID_W-1:0]             pri_id,
    input  logic [PRI_W-1:0]            pri_val,
    output logic [N_IRQ-1:0][PRI_W-1:0] pri_q
);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_pri
        always_ff @(posedge clk) begin
            if (!rst_n)
                pri_q[g] <= '0;
            else if (pri_wr && pri_id == ID_W'(g))
                pri_q[g] <= pri_val;
        end
    end

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_IRQ  = 96,
    localparam int unsigned LVLS  = $clog2(N_IRQ),
    localparam int unsigned LEAF  = 1 << LVLS
)(
    input  logic [N_IRQ-1:0]            live,
    input  logic [N_IRQ-1:0][PRI_W-1:0] pri,
    output logic [PRI_W:0]              best_pri,
    output logic [ID_W-1:0]             best_id
);

    cand_t node [1:2*LEAF-1];

    always_comb begin
        for (int i = 0; i < LEAF; i++) begin
            if (i < N_IRQ && live[i])
                node[LEAF+i] = '{pri: {1'b0, pri[i]}, id: ID_W'(i)};
            else
                node[LEAF+i] = '{pri: {1'b1, {PRI_W{1'b0}}}, id: NO_IRQ};
        end
        // left child holds the lower IDs, so it wins a tie
        for (int n = LEAF - 1; n >= 1; n--) begin
            if (node[2*n].pri <= node[2*n+1].pri)
                node[n] = node[2*n];
            else
                node[n] = node[2*n+1];
        end
    end

    assign best_pri = node[1].pri;
    assign best_id  = node[1].id;

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_IRQ    = 96,
    parameter int unsigned EXT_BASE = 32,
    parameter int unsigned N_BOOT   = 15,
    parameter logic [7:0]  MASK_RST = 8'hF0,
    localparam int unsigned N_EXT   = N_IRQ - EXT_BASE
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic              glb_en_wr,
    input  logic              glb_en_val,
    input  logic              cpu_en_wr,
    input  logic              cpu_en_val,
    input  logic              mask_wr,
    input  logic [7:0]        mask_val,
    input  logic [N_IRQ-1:0]  en_set,
    input  logic [N_IRQ-1:0]  en_clr,
    input  logic [N_IRQ-1:0]  pend_set,
    input  logic [N_IRQ-1:0]  pend_clr,
    input  logic              cfg_wr,
    input  logic [9:0]        cfg_id,
    input  logic              cfg_edge,
    input  logic              pri_wr,
    input  logic [9:0]        pri_id,
    input  logic [7:0]        pri_val,
    input  logic [8:0]        run_pri,
    output logic              irq_req,
    output logic [9:0]        hp_id
);

    logic [N_IRQ-1:0]            en_q, pd_q, lvl_q, edge_q;
    logic [N_IRQ-1:0][PRI_W-1:0] pri_q;
    logic                        glb_en_q, cpu_en_q;
    logic [PRI_W-1:0]            mask_q;
    logic [PRI_W:0]              best_pri;
    logic [ID_W-1:0]             best_id;
    logic                        req_d;
    logic [ID_W-1:0]             id_d;

    irq_line_bank #(.N_IRQ(N_IRQ), .EXT_BASE(EXT_BASE), .N_BOOT(N_BOOT)) u_bank (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_irq),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pend_set), .pd_clr(pend_clr),
        .cfg_wr(cfg_wr), .cfg_id(cfg_id), .cfg_edge(cfg_edge),
        .en_q(en_q), .pd_q(pd_q), .lvl_q(lvl_q), .edge_q(edge_q)
    );

    irq_pri_store #(.N_IRQ(N_IRQ)) u_pri (
        .clk(clk), .rst_n(rst_n), .pri_wr(pri_wr), .pri_id(pri_id),
        .pri_val(pri_val), .pri_q(pri_q)
    );

    irq_pick_tree #(.N_IRQ(N_IRQ)) u_tree (
        .live(en_q & pd_q), .pri(pri_q),
        .best_pri(best_pri), .best_id(best_id)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en_q <= 1'b0;
            cpu_en_q <= 1'b0;
            mask_q   <= MASK_RST;
        end else begin
            if (glb_en_wr) glb_en_q <= glb_en_val;
            if (cpu_en_wr) cpu_en_q <= cpu_en_val;
            if (mask_wr)   mask_q   <= mask_val;
        end
    end

    always_comb begin
        req_d = 1'b0;
        id_d  = NO_IRQ;
        if (glb_en_q && cpu_en_q && best_pri <= {1'b0, mask_q}) begin
            id_d  = best_id;
            req_d = (best_pri < run_pri);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            hp_id   <= NO_IRQ;
        end else begin
            irq_req <= req_d;
            hp_id   <= id_d;
        end
    end

endmodule

module irq_sel_chk
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_IRQ = 96
)(
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             cpu_en,
    input logic [7:0]       mask,
    input logic [8:0]       best_pri,
    input logic [8:0]       run_pri,
    input logic [N_IRQ-1:0] pend_set,
    input logic [N_IRQ-1:0] pend_clr,
    input logic [N_IRQ-1:0] pd_q,
    input logic             irq_req,
    input logic [9:0]       hp_id
);

    a_r3_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(glb_en && cpu_en)) |-> (!irq_req && hp_id == NO_IRQ));

    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(glb_en && cpu_en && best_pri > {1'b0, mask}) |-> (!irq_req && hp_id == NO_IRQ));

    a_r5_below_running: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(best_pri < run_pri));

    a_r5_valid_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (hp_id < 10'(N_IRQ)));

    a_r1_id_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_id < 10'(N_IRQ)) || (hp_id == NO_IRQ));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend_set & pend_clr) & ~pd_q) == '0));

endmodule

bind irq_prio_select irq_sel_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en_q), .cpu_en(cpu_en_q),
    .mask(mask_q), .best_pri(best_pri), .run_pri(run_pri),
    .pend_set(pend_set), .pend_clr(pend_clr), .pd_q(pd_q),
    .irq_req(irq_req), .hp_id(hp_id)
);

// File: tb/sim_irq_prio_select.sv
`timescale 1ns/1ps
module sim_irq_prio_select;

    localparam int N = 96;
    localparam int B = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-B-1:0] ext_irq = '0;
    logic         glb_en_wr = 0, glb_en_val = 0, cpu_en_wr = 0, cpu_en_val = 0;
    logic         mask_wr = 0;
    logic [7:0]   mask_val = '0;
    logic [N-1:0] en_set = '0, en_clr = '0, pend_set = '0, pend_clr = '0;
    logic         cfg_wr = 0, cfg_edge = 0, pri_wr = 0;
    logic [9:0]   cfg_id = '0, pri_id = '0;
    logic [7:0]   pri_val = '0;
    logic [8:0]   run_pri = 9'h100;
    logic         irq_req;
    logic [9:0]   hp_id;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference
    bit m_en[N], m_pd[N], m_lvl[N], m_edge[N];
    int m_pri[N];
    bit m_g, m_c;
    int m_mask;
    bit exp_req;
    int exp_id;

    always #2 clk = ~clk;

    irq_prio_select u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
        .glb_en_wr(glb_en_wr), .glb_en_val(glb_en_val),
        .cpu_en_wr(cpu_en_wr), .cpu_en_val(cpu_en_val),
        .mask_wr(mask_wr), .mask_val(mask_val),
        .en_set(en_set), .en_clr(en_clr), .pend_set(pend_set), .pend_clr(pend_clr),
        .cfg_wr(cfg_wr), .cfg_id(cfg_id), .cfg_edge(cfg_edge),
        .pri_wr(pri_wr), .pri_id(pri_id), .pri_val(pri_val),
        .run_pri(run_pri), .irq_req(irq_req), .hp_id(hp_id)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_en[i] = (i < 15); m_edge[i] = (i < 15);
            m_pd[i] = 0; m_lvl[i] = 0; m_pri[i] = 0;
        end
        m_g = 0; m_c = 0; m_mask = 'hF0;
    endtask

    task automatic compare(string tag);
        n_cmp++;
        if (irq_req !== exp_req || hp_id !== 10'(exp_id)) begin
            n_bad++;
            $display("FAIL %s: irq_req=%0b hp_id=%0d, expected irq_req=%0b hp_id=%0d",
                     tag, irq_req, hp_id, exp_req, exp_id);
        end
    endtask

    // called just after a falling edge with the inputs for the next edge set
    task automatic cyc(string tag);
        int best, bid;
        bit n_en[N], n_pd[N];
        best = 256; bid = 1023;
        for (int i = 0; i < N; i++)
            if (m_en[i] && m_pd[i] && m_pri[i] < best) begin best = m_pri[i]; bid = i; end
        if (!(m_g && m_c) || best > m_mask) begin exp_req = 0; exp_id = 1023; end
        else begin exp_id = bid; exp_req = (best < int'(run_pri)); end
        for (int i = 0; i < N; i++) begin
            bit w, sp;
            w = 0;
            if (i >= B) w = ext_irq[i-B];
            sp = pend_set[i] || (w && !m_lvl[i] && (m_edge[i] || m_en[i]))
                 || (en_set[i] && m_lvl[i] && !m_edge[i]);
            n_pd[i] = sp ? 1'b1 : (pend_clr[i] ? 1'b0 : m_pd[i]);
            n_en[i] = en_set[i] ? 1'b1 : (en_clr[i] ? 1'b0 : m_en[i]);
            m_lvl[i] = w;
        end
        for (int i = 0; i < N; i++) begin
            m_pd[i] = n_pd[i]; m_en[i] = n_en[i];
        end
        if (cfg_wr && cfg_id < N) m_edge[cfg_id] = cfg_edge;
        if (pri_wr && pri_id < N) m_pri[pri_id] = pri_val;
        if (glb_en_wr) m_g = glb_en_val;
        if (cpu_en_wr) m_c = cpu_en_val;
        if (mask_wr) m_mask = mask_val;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        glb_en_wr = 0; cpu_en_wr = 0; mask_wr = 0; cfg_wr = 0; pri_wr = 0;
        en_set = '0; en_clr = '0; pend_set = '0; pend_clr = '0;
    endtask

    task automatic idle(string tag, int k);
        for (int i = 0; i < k; i++) cyc(tag);
    endtask

    task automatic set_pri(int id, int v, string tag);
        pri_wr = 1; pri_id = 10'(id); pri_val = 8'(v); cyc(tag);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R9: outputs held in their reset values
        exp_req = 0; exp_id = 1023; compare("R9");
        rst_n = 1;
        idle("R9", 2);

        // R3: pending exists but both enables are off
        pend_set[5] = 1; cyc("R3");
        pend_set[20] = 1; idle("R3", 2);
        glb_en_wr = 1; glb_en_val = 1; idle("R3", 2);
        cpu_en_wr = 1; cpu_en_val = 1; idle("R9", 3);   // ID 5 enabled by reset, 20 not

        // R5: running priority gating
        run_pri = 9'h000; idle("R5", 2);
        run_pri = 9'h100; idle("R5", 2);

        // R2: equal priority, lower ID wins; lower value beats
        set_pri(5, 'h40, "R2"); set_pri(7, 'h40, "R2");
        pend_set[7] = 1; idle("R2", 2);
        set_pri(9, 'h10, "R2"); pend_set[9] = 1; idle("R2", 2);
        en_set[20] = 1; set_pri(20, 'h05, "R2"); idle("R2", 2);
        en_clr[20] = 1; idle("R2", 2);

        // R5: running equal to winner's priority keeps request low
        run_pri = 9'h010; idle("R5", 2);
        run_pri = 9'h011; idle("R5", 2);
        run_pri = 9'h100;

        // R4: mask below, equal to, above
        mask_wr = 1; mask_val = 8'h08; idle("R4", 2);
        mask_wr = 1; mask_val = 8'h10; idle("R4", 2);
        pend_clr[5] = 1; pend_clr[7] = 1; pend_clr[9] = 1; idle("R4", 3);
        mask_wr = 1; mask_val = 8'hFF; idle("R4", 2);

        // R6 / R8: level line 40 (wire 8) disabled then enabled
        set_pri(40, 'h20, "R1");
        ext_irq[8] = 1; idle("R6", 3);
        en_set[40] = 1; idle("R8", 3);
        pend_clr[40] = 1; idle("R6", 3);            // wire steady high: ignored
        ext_irq[8] = 0; idle("R7", 2);

        // R6 / R7: edge line 41 (wire 9) pends while disabled
        cfg_wr = 1; cfg_id = 10'd41; cfg_edge = 1; cyc("R6");
        set_pri(41, 'h30, "R1");
        ext_irq[9] = 1; idle("R6", 2);
        ext_irq[9] = 0; idle("R7", 2);
        en_set[41] = 1; idle("R7", 3);

        // R6: enabled level line rises
        en_set[60] = 1; set_pri(60, 'h01, "R1");
        ext_irq[28] = 1; idle("R6", 3);
        ext_irq[28] = 0; pend_clr[60] = 1; idle("R7", 2);

        // R10: simultaneous set and clear
        en_set[50] = 1; en_clr[50] = 1; pend_set[50] = 1; pend_clr[50] = 1; idle("R10", 3);
        pend_clr[50] = 1; pend_clr[41] = 1; idle("R10", 2);

        // R11: a running priority change reaches the output after one edge
        run_pri = 9'h000; idle("R11", 1);
        run_pri = 9'h100; idle("R11", 1);

        // R1: highest external wire maps to ID 95
        en_set[95] = 1; cyc("R1");
        ext_irq[63] = 1; idle("R1", 3);
        glb_en_wr = 1; glb_en_val = 0; idle("R3", 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule